// File: doc/BRIEF.md
# Four-Mode Timer with Variable-Width PWM

This block is a 16-bit counting unit made of a low byte and a high byte. A two-bit mode input sets how the bytes work together. They can run as two separate 8-bit interval timers, as an 8-bit timer beside an 8-bit pulse-width modulator, as one cascaded 16-bit timer, or as a single pulse-width modulator whose period is a power of two between 9 and 16 bits wide. The CPU loads period and compare bytes through a small write port. A compare value only takes effect at the end of a period, so a write never cuts a pulse short.

The count advances on an instruction-cycle enable. In the two 16-bit modes it can instead advance on a half-cycle enable, which doubles the resolution. Each byte has its own event flag. Both flags feed one shared interrupt request, and software clears either flag by writing a one to it.

Top module: `var_pwm_timer`

## Requirements
- R1: After the active-low asynchronous reset, pwm_o, flag_lo_o, flag_hi_o and irq_o are 0, and every counter, period, compare and active-compare register is 0.
- R2: Register map on wr_addr_i: address 0 is the period low byte, 1 the period high byte, 2 the compare low byte, 3 the compare high byte. A write to address 4 is a flag clear (R8). In mode 0 (mode_i=0) each byte counts up independently. A byte that has reached or passed its period byte reloads 0 on its next step and sets its own flag (low byte sets flag_lo_o, high byte sets flag_hi_o). pwm_o is 0.
- R3: In mode 1 the low byte is a timer as in R2. The high byte counts the same way, and pwm_o is 1 while the high count is below the active high compare byte.
- R4: In mode 2 the two bytes form one 16-bit counter. It reloads 0 on the step after it reaches or passes {period high, period low}. That reload sets flag_hi_o only. flag_lo_o is never set, and pwm_o is 0.
- R5: In mode 3 the 16-bit counter has a width of 9 plus period-high bits [2:0]. It wraps to 0 on the step after the all-ones value of that width and sets flag_hi_o on the wrap. pwm_o is 1 while the count is below the 16-bit active compare.
- R6: In modes 0 and 1 the count steps on tick_i, and fine_i and half_i are ignored. In modes 2 and 3 it steps on half_i when fine_i is 1, and on tick_i when fine_i is 0.
- R7: The active compare is loaded from the written compare bytes only on a high-byte or 16-bit reload event in modes 1 and 3. A compare write mid-period does not change pwm_o until the next period.
- R8: A write to address 4 clears flag_lo_o when data bit 0 is 1 and clears flag_hi_o when data bit 1 is 1. An event in the same cycle keeps its flag set.
- R9: irq_o is 1 whenever either flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-cycle count enable |
| half_i | input | 1 | Half-cycle count enable |
| mode_i | input | 2 | Mode select 0..3 |
| fine_i | input | 1 | Select half-cycle resolution in modes 2 and 3 |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 1 | PWM output |
| flag_lo_o | output | 1 | Low-byte event flag |
| flag_hi_o | output | 1 | High-byte or 16-bit event flag |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is the full 16-bit variable-width period in mode 3. Its wrap and the compare hand-over come only after 65536 steps. The bench reaches it by driving a half-cycle enable on every clock with fine resolution selected, so a full period fits in the run. A flag set that lands on the same cycle as a clear write needs exact cycle alignment. The bench forces it by issuing clear writes on every cycle while a short period produces events. A compare rewrite is placed in the middle of a running 9-bit period, and the reference model checks that the old duty cycle holds until the wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT   = 2'd0,
    MODE_TMR_PWM = 2'd1,
    MODE_CASCADE = 2'd2,
    MODE_VARPWM  = 2'd3
  } tmr_mode_e;

  localparam int unsigned ADR_PRD_LO = 0;
  localparam int unsigned ADR_PRD_HI = 1;
  localparam int unsigned ADR_CMP_LO = 2;
  localparam int unsigned ADR_CMP_HI = 3;
  localparam int unsigned ADR_CLR    = 4;
  localparam int unsigned NUM_REGS   = 4;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  output logic [2*BYTE_W-1:0] prd_o,
  output logic [2*BYTE_W-1:0] cmp_o,
  output logic [1:0]          clr_o
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_addr_i == ADDR_W'(i)) reg_q[i] <= wr_data_i;
      end
    end
  end

  assign prd_o = {reg_q[ADR_PRD_HI], reg_q[ADR_PRD_LO]};
  assign cmp_o = {reg_q[ADR_CMP_HI], reg_q[ADR_CMP_LO]};
  assign clr_o = (wr_i && wr_addr_i == ADDR_W'(ADR_CLR)) ? wr_data_i[1:0] : 2'b00;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tmr_mode_e           mode_i,
  input  logic                step_i,
  input  logic [2*BYTE_W-1:0] prd_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                evt_lo_o,
  output logic                evt_hi_o
);
  localparam int W2    = 2 * BYTE_W;
  localparam int SEL_W = $clog2(BYTE_W);

  logic [W2-1:0]     cnt_q, mask, lim;
  logic [BYTE_W-1:0] lo, hi;
  logic [SEL_W-1:0]  sel, shamt;
  logic              wide, end_lo, end_hi, end_w;

  assign wide   = mode_i[1];
  assign lo     = cnt_q[BYTE_W-1:0];
  assign hi     = cnt_q[W2-1:BYTE_W];
  // width = BYTE_W+1+sel, so drop (BYTE_W-1-sel) leading ones
  assign sel    = prd_i[BYTE_W +: SEL_W];
  assign shamt  = SEL_W'(BYTE_W - 1) - sel;
  assign mask   = {W2{1'b1}} >> shamt;
  assign lim    = (mode_i == MODE_VARPWM) ? mask : prd_i;
  assign end_lo = lo >= prd_i[BYTE_W-1:0];
  assign end_hi = hi >= prd_i[W2-1:BYTE_W];
  assign end_w  = cnt_q >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (wide) begin
        cnt_q <= end_w ? '0 : cnt_q + W2'(1);
      end else begin
        cnt_q[BYTE_W-1:0]  <= end_lo ? '0 : lo + BYTE_W'(1);
        cnt_q[W2-1:BYTE_W] <= end_hi ? '0 : hi + BYTE_W'(1);
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign evt_lo_o = step_i && !wide && end_lo;
  assign evt_hi_o = step_i && (wide ? end_w : end_hi);
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tmr_mode_e           mode_i,
  input  logic [2*BYTE_W-1:0] cnt_i,
  input  logic [2*BYTE_W-1:0] cmp_i,
  input  logic                evt_hi_i,
  output logic [2*BYTE_W-1:0] act_o,
  output logic                pwm_o
);
  localparam int W2 = 2 * BYTE_W;

  logic [W2-1:0] act_q;

  // staged compare: taken over only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    act_q <= '0;
    else if (evt_hi_i && mode_i[0]) act_q <= cmp_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_TMR_PWM: pwm_o = cnt_i[W2-1:BYTE_W] < act_q[W2-1:BYTE_W];
      MODE_VARPWM:  pwm_o = cnt_i < act_q;
      default:      pwm_o = 1'b0;
    endcase
  end

  assign act_o = act_q;
endmodule

// File: rtl/var_pwm_timer.sv
module var_pwm_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              half_i,
  input  logic [1:0]        mode_i,
  input  logic              fine_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              flag_lo_o,
  output logic              flag_hi_o,
  output logic              irq_o
);
  localparam int W2 = 2 * BYTE_W;

  tmr_mode_e     mode;
  logic [W2-1:0] prd_w, cmp_w, cnt_w, act_w;
  logic [1:0]    clr_w, evt_w, flag_w;
  logic          step;

  assign mode = tmr_mode_e'(mode_i);
  assign step = (mode_i[1] && fine_i) ? half_i : tick_i;

  tmr_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .wr_addr_i, .wr_data_i,
    .prd_o(prd_w), .cmp_o(cmp_w), .clr_o(clr_w)
  );

  tmr_count #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i, .rst_ni, .mode_i(mode), .step_i(step), .prd_i(prd_w),
    .cnt_o(cnt_w), .evt_lo_o(evt_w[0]), .evt_hi_o(evt_w[1])
  );

  tmr_pwm #(.BYTE_W(BYTE_W)) u_pwm (
    .clk_i, .rst_ni, .mode_i(mode), .cnt_i(cnt_w), .cmp_i(cmp_w),
    .evt_hi_i(evt_w[1]), .act_o(act_w), .pwm_o
  );

  for (genvar i = 0; i < 2; i++) begin : g_flag
    logic f_q;
    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) f_q <= 1'b0;
      else         f_q <= evt_w[i] | (f_q & ~clr_w[i]);
    end
    assign flag_w[i] = f_q;
  end

  assign flag_lo_o = flag_w[0];
  assign flag_hi_o = flag_w[1];
  assign irq_o     = |flag_w;
endmodule

// File: rtl/var_pwm_timer_chk.sv
module var_pwm_timer_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                half_i,
  input logic [1:0]          mode_i,
  input logic                fine_i,
  input logic                wr_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [BYTE_W-1:0]   wr_data_i,
  input logic [2*BYTE_W-1:0] cnt_w,
  input logic [2*BYTE_W-1:0] act_w,
  input logic [1:0]          evt_w,
  input logic                flag_lo_o
);
  AST_HOLD_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[1] && !tick_i) |=> $stable(cnt_w)); // R6
  AST_HOLD_COARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !fine_i && !tick_i) |=> $stable(cnt_w)); // R6
  AST_ACT_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_w) |-> (cnt_w[2*BYTE_W-1:BYTE_W] == '0)); // R7
  AST_CLR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_addr_i == ADDR_W'(4) && wr_data_i[0] && !evt_w[0]) |=> !flag_lo_o); // R8
  AST_WIDE_LO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !flag_lo_o) |=> !flag_lo_o); // R4
endmodule

bind var_pwm_timer var_pwm_timer_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .half_i(half_i),
  .mode_i(mode_i), .fine_i(fine_i), .wr_i(wr_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .cnt_w(cnt_w), .act_w(act_w), .evt_w(evt_w),
  .flag_lo_o(flag_lo_o)
);

// File: tb/tb_var_pwm_timer.sv
`timescale 1ns/1ps
module tb_var_pwm_timer;
  logic       clk = 0, rst_n = 0, tick = 0, half = 0, fine = 0, wr = 0;
  logic [1:0] mode = 0;
  logic [2:0] addr = 0;
  logic [7:0] data = 0;
  logic       pwm, flo, fhi, irq;

  always #2.5 clk = ~clk;

  var_pwm_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .half_i(half), .mode_i(mode),
    .fine_i(fine), .wr_i(wr), .wr_addr_i(addr), .wr_data_i(data),
    .pwm_o(pwm), .flag_lo_o(flo), .flag_hi_o(fhi), .irq_o(irq)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0, ph = 0, hdiv = 1;
  string tag = "R1";

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d @%0t", t, act, exp, $time);
    end
  endtask

  // enable generator: half-cycle pulses, tick on every second one
  always @(negedge clk) begin
    ph++;
    half <= (hdiv == 1) ? 1'b1 : ph[0];
    tick <= (hdiv == 1) ? ph[0] : (ph % 4 == 0);
  end

  // reference model
  int m_lo, m_hi, p_lo, p_hi, c_lo, c_hi, a_lo, a_hi, f_lo, f_hi;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; p_lo = 0; p_hi = 0; c_lo = 0; c_hi = 0;
      a_lo = 0; a_hi = 0; f_lo = 0; f_hi = 0;
    end else begin
      bit wide, st, elo, ehi;
      int c16, lim;
      wide = mode >= 2;
      st = (wide && fine) ? half : tick;
      elo = 0; ehi = 0;
      if (st) begin
        if (wide) begin
          c16 = m_hi * 256 + m_lo;
          lim = (mode == 3) ? ((1 << (9 + p_hi % 8)) - 1) : (p_hi * 256 + p_lo);
          if (c16 >= lim) begin c16 = 0; ehi = 1; end else c16++;
          m_hi = c16 / 256; m_lo = c16 % 256;
        end else begin
          if (m_lo >= p_lo) begin m_lo = 0; elo = 1; end else m_lo++;
          if (m_hi >= p_hi) begin m_hi = 0; ehi = 1; end else m_hi++;
        end
      end
      if (ehi && mode % 2 == 1) begin a_lo = c_lo; a_hi = c_hi; end
      if (wr && addr == 4) begin
        if (data[0]) f_lo = 0;
        if (data[1]) f_hi = 0;
      end
      if (elo) f_lo = 1;
      if (ehi) f_hi = 1;
      if (wr) case (addr)
        0: p_lo = data; 1: p_hi = data; 2: c_lo = data; 3: c_hi = data;
        default: ;
      endcase
    end
  end

  // per-cycle comparison, away from the edges
  always @(posedge clk) begin
    int ep;
    #2;
    case (mode)
      1: ep = (m_hi < a_hi);
      3: ep = (m_hi * 256 + m_lo) < (a_hi * 256 + a_lo);
      default: ep = 0;
    endcase
    check(pwm == ep, {tag, " pwm"}, pwm, ep);
    check(flo == f_lo, {tag, " flag_lo"}, flo, f_lo);
    check(fhi == f_hi, {tag, " flag_hi"}, fhi, f_hi);
    check(irq == (f_lo | f_hi), "R9 irq", irq, f_lo | f_hi);
  end

  always @(posedge clk) if (cyc > 190000) begin
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic wreg(input int a, input int d);
    @(negedge clk); wr = 1; addr = 3'(a); data = 8'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic restart(input int md, input bit fn, input int hd);
    @(negedge clk); rst_n = 0; mode = 2'(md); fine = fn; hdiv = hd;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hits;
    idle(3);
    #1;
    check({pwm, flo, fhi, irq} == 4'b0, "R1 reset outputs", {pwm, flo, fhi, irq}, 0);
    rst_n = 1;

    tag = "R2";
    restart(0, 1, 1);  // fine=1 must be ignored in mode 0 (R6)
    wreg(0, 5); wreg(1, 9);
    idle(60);
    check(flo && fhi, "R2 both flags set", {flo, fhi}, 3);
    tag = "R8";
    wreg(4, 1);
    #1 check(!flo || dut.flag_lo_o == flo, "R8 clear lo", flo, 0);
    idle(1);
    wreg(0, 3);
    @(negedge clk); wr = 1; addr = 4; data = 3;
    idle(20);
    wr = 0;

    tag = "R3";
    restart(1, 0, 1);
    wreg(1, 19); wreg(3, 7); wreg(0, 4);
    hits = 0;
    repeat (200) begin @(negedge clk); if (pwm) hits++; end
    check(hits > 0, "R3 pwm active", hits, 1);

    tag = "R4";
    restart(2, 0, 1);
    wreg(0, 8'h23); wreg(1, 8'h01);
    idle(800);
    fine = 1; tag = "R6";
    idle(800);
    check(!flo && fhi, "R4 wide flags", {flo, fhi}, 1);

    tag = "R5";
    restart(3, 1, 2);
    wreg(1, 0); wreg(2, 8'hC0); wreg(3, 0);
    idle(1500);
    tag = "R7";
    wreg(2, 8'h80); wreg(3, 8'h01);
    idle(1200);
    fine = 0;
    idle(600);

    tag = "R5";
    restart(3, 1, 1);
    wreg(1, 7); wreg(3, 8'h80); wreg(2, 0);
    idle(65700);
    check(fhi == 1, "R5 16-bit wrap flag", fhi, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule